// File: doc/BRIEF.md
# Pulsed Overload Protection Timer

This block decides, for one regulator channel, whether the power stage may drive its output. It watches an asynchronous overload comparator, a channel enable and a mode select. It also watches a pair of thermal comparators: one reports the junction is above the upper threshold, the other reports it has cooled below the lower one.

In dynamic (hiccup) mode, an overload shuts the output off for a long interval. The output is then tried again for a probation window one tenth as long. The block repeats this until a whole probation window passes with no overload. In static mode the analog clamp handles the current, so the output stays on and the overload flag simply tracks the comparator. The thermal flag uses hysteresis and forces the output off while it is set.

The interval lengths are counted in ticks of a prescaled clock. Simulation can therefore use short values, and silicon can use the long ones.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: With mode select low (dynamic), output enabled and overload asserted, `out_en_o` falls on the third rising clock edge after the overload input rises. `olf_o` is then 1. The output stays off for exactly OFF_TICKS*PRESCALE clock cycles (120 with defaults).
- R2: After the off interval, the output is re-enabled for a probation window of (OFF_TICKS/ON_RATIO)*PRESCALE cycles (12 with defaults). `olf_o` stays 1 during the window.
- R3: If overload is seen at any cycle of the probation window, another full off interval follows the window.
- R4: When a probation window passes with no overload, the block returns to normal operation. `olf_o` falls on the clock edge that ends the window and not earlier.
- R5: With mode select high (static), the output is never switched off by the timer. `olf_o` equals the synchronized overload input, lagging it by two clock edges.
- R6: Raising mode select while an off interval or probation window is running restores the output on the next clock edge.
- R7: `otf_o` rises when the hot comparator is high and falls when the cool comparator is high. The hot comparator wins if both are high. `otf_o` holds while both are low. While `otf_o` is 1 the output is off.
- R8: `en_i` low forces `out_en_o` low in the same cycle. It also abandons any retry in progress, so `olf_o` is 0 one clock edge later.
- R9: Overload is ignored while the output is disabled by `en_i` or `otf_o`. It leaves no pending trip once the output is enabled again.
- R10: While `rst_ni` is low, `olf_o` and `otf_o` are 0, and `out_en_o` is 0 whenever `en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; 0 = standby |
| pcl_i | input | 1 | Protection mode: 0 = dynamic hiccup, 1 = static clamp |
| ovl_i | input | 1 | Overload comparator, asynchronous |
| temp_hot_i | input | 1 | Junction above upper thermal threshold, asynchronous |
| temp_cool_i | input | 1 | Junction below lower thermal threshold, asynchronous |
| out_en_o | output | 1 | Power stage enable |
| olf_o | output | 1 | Overload flag |
| otf_o | output | 1 | Over-temperature flag |

## Verification
A persistent overload in dynamic mode measures the trip latency, the off length and the probation length. It also shows that a fault still present during probation causes a second off interval. Removing the overload during that second interval tells a clean probation apart from a faulty one, and shows that the flag clears exactly at the window's end. Static-mode patterns with the overload toggling show the flag tracking the input with no timer action. Raising the mode select mid-interval shows the immediate release. Thermal patterns step through hot, in-band and cool to separate set, hold and clear. Overload applied while in standby or while over-temperature, then removed before re-enabling, shows whether any hidden trip is left behind.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_OFF = 2'd1,
    ST_ON  = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pcnt_q;

  assign tick_o = (pcnt_q == PW'(PRESCALE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pcnt_q <= '0;
    else if (clr_i)    pcnt_q <= '0;
    else if (tick_o)   pcnt_q <= '0;
    else               pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/ocp_thermal.sv
module ocp_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic cool_i,
  output logic otf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     otf_o <= 1'b0;
    else if (hot_i)  otf_o <= 1'b1;
    else if (cool_i) otf_o <= 1'b0;
  end
endmodule

// File: rtl/ocp_hiccup_fsm.sv
module ocp_hiccup_fsm
  import ocp_pkg::*;
#(
  parameter int OFF_TICKS = 30,
  parameter int ON_RATIO  = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       dyn_i,
  input  logic       gate_i,
  input  logic       ovl_i,
  output ocp_state_e state_o,
  output logic       restart_o
);
  localparam int ON_TICKS = (OFF_TICKS / ON_RATIO > 0) ? OFF_TICKS / ON_RATIO : 1;
  localparam int CW       = $clog2(OFF_TICKS + 1);

  ocp_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    seen_d    = seen_q;
    restart_o = 1'b0;
    if (!dyn_i || !gate_i) begin
      state_d = ST_RUN;
      seen_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (ovl_i) begin
            state_d   = ST_OFF;
            cnt_d     = CW'(OFF_TICKS - 1);
            restart_o = 1'b1;
          end
        end
        ST_OFF: begin
          if (tick_i) begin
            if (cnt_q == '0) begin
              state_d   = ST_ON;
              cnt_d     = CW'(ON_TICKS - 1);
              seen_d    = 1'b0;
              restart_o = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        ST_ON: begin
          if (ovl_i) seen_d = 1'b1;
          if (tick_i) begin
            if (cnt_q == '0) begin
              if (seen_d) begin
                state_d   = ST_OFF;
                cnt_d     = CW'(OFF_TICKS - 1);
                restart_o = 1'b1;
              end else begin
                state_d = ST_RUN;
              end
              seen_d = 1'b0;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
module ocp_hiccup_ctrl
  import ocp_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int OFF_TICKS   = 30,
  parameter int ON_RATIO    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pcl_i,
  input  logic ovl_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  output logic out_en_o,
  output logic olf_o,
  output logic otf_o
);
  logic [2:0] raw_in, sync_out;
  logic       ovl_s, hot_s, cool_s;
  logic       gate, tick, restart;
  ocp_state_e state;

  assign raw_in = {ovl_i, temp_hot_i, temp_cool_i};

  ocp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign {ovl_s, hot_s, cool_s} = sync_out;

  ocp_thermal u_therm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hot_i (hot_s),
    .cool_i(cool_s),
    .otf_o (otf_o)
  );

  assign gate = en_i & ~otf_o;

  ocp_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (restart),
    .tick_o(tick)
  );

  ocp_hiccup_fsm #(.OFF_TICKS(OFF_TICKS), .ON_RATIO(ON_RATIO)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .dyn_i    (~pcl_i),
    .gate_i   (gate),
    .ovl_i    (ovl_s),
    .state_o  (state),
    .restart_o(restart)
  );

  assign out_en_o = gate & (state != ST_OFF);
  assign olf_o    = pcl_i ? (ovl_s & gate) : (state != ST_RUN);
endmodule

// File: rtl/ocp_hiccup_chk.sv
module ocp_hiccup_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pcl_i,
  input logic out_en_o,
  input logic olf_o,
  input logic otf_o,
  input logic hot_s_i,
  input logic cool_s_i
);
  // R1: an enabled, non-overheated channel that is held off must be flagging overload
  a_r1_off_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !otf_o && !out_en_o) |-> olf_o);

  // R5: static mode held for a cycle never leaves the output off
  a_r5_static_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_i && $past(pcl_i) && en_i && !otf_o) |-> out_en_o);

  // R7: thermal flag holds inside the hysteresis band
  a_r7_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hot_s_i && !cool_s_i) |=> (otf_o == $past(otf_o)));

  // R7: over-temperature keeps the output off
  a_r7_otf_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otf_o |-> !out_en_o);

  // R8: standby keeps the output off
  a_r8_en_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !out_en_o);

  // R4: in dynamic mode the flag only clears with the output running
  a_r4_clear_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(olf_o) && $past(!pcl_i) && !pcl_i && en_i && !otf_o) |-> out_en_o);
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .pcl_i   (pcl_i),
  .out_en_o(out_en_o),
  .olf_o   (olf_o),
  .otf_o   (otf_o),
  .hot_s_i (hot_s),
  .cool_s_i(cool_s)
);

// File: tb/tb_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module tb_ocp_hiccup_ctrl;
  localparam int PRESCALE  = 4;
  localparam int OFF_TICKS = 30;
  localparam int ON_RATIO  = 10;
  localparam int OFF_CYC   = OFF_TICKS * PRESCALE;
  localparam int ON_CYC    = (OFF_TICKS / ON_RATIO) * PRESCALE;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, pcl_i = 1'b0, ovl_i = 1'b0;
  logic temp_hot_i = 1'b0, temp_cool_i = 1'b1;
  logic out_en_o, olf_o, otf_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ocp_hiccup_ctrl #(
    .PRESCALE(PRESCALE), .OFF_TICKS(OFF_TICKS), .ON_RATIO(ON_RATIO), .SYNC_STAGES(2)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .pcl_i(pcl_i), .ovl_i(ovl_i),
    .temp_hot_i(temp_hot_i), .temp_cool_i(temp_cool_i),
    .out_en_o(out_en_o), .olf_o(olf_o), .otf_o(otf_o)
  );

  // {en, pcl, ovl, hot, cool, exp_out, exp_olf, exp_otf}
  localparam logic [7:0] VEC [11] = '{
    8'b1_1_0_0_1_1_0_0,  // R5 static nominal
    8'b1_1_1_0_1_1_1_0,  // R5 static overload: flag, output stays on
    8'b1_1_0_0_1_1_0_0,  // R5 flag follows back low
    8'b0_1_1_0_1_0_0_0,  // R8 R9 standby
    8'b1_1_0_1_0_0_0_1,  // R7 hot
    8'b1_1_0_0_0_0_0_1,  // R7 band hold
    8'b1_1_1_0_0_0_0_1,  // R9 overload ignored while hot
    8'b1_1_0_0_1_1_0_0,  // R7 cooled
    8'b0_0_1_0_1_0_0_0,  // R9 dynamic standby with overload
    8'b0_0_0_0_1_0_0_0,  // R9 overload removed
    8'b1_0_0_0_1_1_0_0   // R9 no pending trip
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (out_en_o === lvl && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    cyc(3);
    check("R10", "out_en in reset", out_en_o, 0);
    check("R10", "olf in reset", olf_o, 0);
    check("R10", "otf in reset", otf_o, 0);
    rst_ni = 1'b1;
    cyc(2);

    for (int i = 0; i < 11; i++) begin
      {en_i, pcl_i, ovl_i, temp_hot_i, temp_cool_i} = VEC[i][7:3];
      cyc(4);
      check("VEC", $sformatf("vec%0d out_en", i), out_en_o, VEC[i][2]);
      check("VEC", $sformatf("vec%0d olf", i), olf_o, VEC[i][1]);
      check("VEC", $sformatf("vec%0d otf", i), otf_o, VEC[i][0]);
    end

    // R1 trip latency and off length
    ovl_i = 1'b1;
    n = 0;
    while (out_en_o === 1'b1 && n < 50) begin
      @(negedge clk_i);
      n++;
    end
    check("R1", "trip latency", n, 3);
    check("R1", "olf at trip", olf_o, 1);
    count_level(1'b0, n);
    check("R1", "off length", n, OFF_CYC);
    // R2 probation length, R3 retry with persistent fault
    check("R2", "olf in window", olf_o, 1);
    count_level(1'b1, n);
    check("R2", "window length", n, ON_CYC);
    // R3 second off interval; fault removed inside it
    ovl_i = 1'b0;
    count_level(1'b0, n);
    check("R3", "second off length", n, OFF_CYC);
    // R4 clean window clears the flag at its end only
    cyc(ON_CYC - 1);
    check("R4", "olf before window end", olf_o, 1);
    cyc(1);
    check("R4", "olf at window end", olf_o, 0);
    check("R4", "output on after clean window", out_en_o, 1);
    cyc(200);
    check("R4", "output stays on", out_en_o, 1);

    // R6 mode switch releases an off interval
    ovl_i = 1'b1;
    cyc(6);
    check("R6", "off before switch", out_en_o, 0);
    pcl_i = 1'b1;
    ovl_i = 1'b0;
    cyc(1);
    check("R6", "output one edge after switch", out_en_o, 1);
    cyc(4);
    check("R5", "static flag low", olf_o, 0);

    // R8 standby abandons a retry
    pcl_i = 1'b0;
    ovl_i = 1'b1;
    cyc(6);
    check("R8", "off before standby", olf_o, 1);
    en_i = 1'b0;
    ovl_i = 1'b0;
    #1;
    check("R8", "output off same cycle", out_en_o, 0);
    cyc(1);
    check("R8", "olf one edge after standby", olf_o, 0);
    cyc(4);
    en_i = 1'b1;
    cyc(4);
    check("R8", "output back after standby", out_en_o, 1);
    check("R8", "olf after standby", olf_o, 0);

    finish_run();
  end
endmodule